// File: doc/BRIEF.md
# Programmable Audio Frame Serializer

This block is the transmit side of a serial audio link in which it owns the timing. It divides the system clock down to a bit clock. It produces a phase-select line that marks the first and second half of each frame. It shifts out one left sample and one right sample per frame on a single data line. The two halves of a frame need not be equal. Each half has its own sample width and its own count of idle bit slots before its data begins. The frame length can be chosen from seven sizes.

Software writes the whole configuration in one strobe while the serializer is idle. A write is checked before it is stored, and a write made while frames are being produced is refused. An upstream source supplies sample pairs over a valid/ready handshake. The block holds one pair in reserve and takes it at the first slot of every frame. If no pair is waiting at that moment, the frame is sent as silence and a one-cycle underrun pulse is raised.

Top module: `i2s_frame_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `bclk`, `ws` and `sdo` are held low and `running` is low. After reset `smp_ready` is high. The reset configuration is a 64-slot frame, a 32-slot left phase, 16-bit samples in both phases, one delay slot in each phase, and a half-period of 2 system clocks.
- R2: A `start` pulse while idle begins frame generation at slot 0. A `start` pulse while running changes nothing. A `stop` pulse while running returns every output to its idle level on the next clock. A `stop` pulse while idle changes nothing. If both arrive together, `stop` wins.
- R3: The bit clock has a period of 2×`cfg_half_div` system clocks. It starts low, and its first rise comes `cfg_half_div` clocks after the start. `ws` and `sdo` change only together with a falling edge of `bclk`, so they are stable at each rising edge.
- R4: Frame-length codes 0 to 6 on `cfg_frame_code` select 16, 24, 32, 48, 64, 96 or 128 slots. `ws` is 0 for the first `cfg_left_len` slots of a frame and 1 for the rest.
- R5: Width codes 0 to 4 select 8, 12, 16, 24 or 32 bits. Samples are right-justified in the 32-bit sample inputs, their upper bits are ignored, and they are sent most significant bit first.
- R6: Within each phase, the first delay-count slots are driven low, the sample bits follow, and any remaining slots of the phase are driven low. A delay of zero puts the MSB in the phase's first slot.
- R7: A pair is accepted when `smp_valid` and `smp_ready` are both high, after which `smp_ready` falls. The stored pair is consumed at slot 0 of the next frame, and `smp_ready` then rises again.
- R8: If no pair is stored at slot 0 of a frame, `underrun` is high for exactly one clock and the whole frame carries zero data.
- R9: A configuration write while running is refused. `cfg_busy` is then 1 and `cfg_err` is 0, and frames continue with the old settings. A write while idle clears `cfg_busy`.
- R10: An idle write is rejected and `cfg_err` set to 1, with the old settings kept, if any of these holds: a code is out of range, the half-period is 0, the left length exceeds the frame, the left length is under left delay plus left width, or the rest of the frame is under right delay plus right width. A valid idle write clears `cfg_err` and takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin frame generation |
| stop | input | 1 | End frame generation |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_frame_code | input | 3 | Frame length code |
| cfg_left_len | input | 8 | Left phase length in slots |
| cfg_left_wcode | input | 3 | Left sample width code |
| cfg_right_wcode | input | 3 | Right sample width code |
| cfg_left_delay | input | 8 | Idle slots before left data |
| cfg_right_delay | input | 8 | Idle slots before right data |
| cfg_half_div | input | 8 | Bit-clock half-period in system clocks |
| cfg_busy | output | 1 | Last write was refused because the block was running |
| cfg_err | output | 1 | Last idle write was rejected as inconsistent |
| running | output | 1 | Frames are being generated |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Reserve slot is empty |
| smp_left | input | 32 | Left sample, right-justified |
| smp_right | input | 32 | Right sample, right-justified |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Phase select, 0 for left |
| sdo | output | 1 | Serial data |
| underrun | output | 1 | One-clock pulse when a frame starts with no pair stored |

## Verification
The properties assume that `start`, `stop`, `cfg_we` and `smp_valid` are sampled on the rising system clock and settle well before it. The underrun property also assumes that a frame is longer than two system clocks, which every legal frame length and divider satisfies. The stimulus changes every input on the falling system clock and raises each control strobe for exactly one cycle. It offers a new sample pair only once `smp_ready` has risen, so no pair is presented during the cycle in which the reserve is consumed. Configuration writes that are expected to succeed are issued only while idle. Writes made during a run exist only to exercise the refusal path.

// File: rtl/i2s_frame_tx.sv
module i2s_frame_tx #(
  parameter int SMP_W = 32,
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_frame_code,
  input  logic [CNT_W-1:0] cfg_left_len,
  input  logic [2:0]       cfg_left_wcode,
  input  logic [2:0]       cfg_right_wcode,
  input  logic [CNT_W-1:0] cfg_left_delay,
  input  logic [CNT_W-1:0] cfg_right_delay,
  input  logic [DIV_W-1:0] cfg_half_div,
  output logic             cfg_busy,
  output logic             cfg_err,
  output logic             running,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic             bclk,
  output logic             ws,
  output logic             sdo,
  output logic             underrun
);
  localparam int EW = CNT_W + 2;
  typedef logic [EW-1:0] ext_t;

  function automatic ext_t frame_of(input logic [2:0] c);
    case (c)
      3'd0:    frame_of = EW'(16);
      3'd1:    frame_of = EW'(24);
      3'd2:    frame_of = EW'(32);
      3'd3:    frame_of = EW'(48);
      3'd4:    frame_of = EW'(64);
      3'd5:    frame_of = EW'(96);
      3'd6:    frame_of = EW'(128);
      default: frame_of = '0;
    endcase
  endfunction

  function automatic ext_t width_of(input logic [2:0] c);
    case (c)
      3'd0:    width_of = EW'(8);
      3'd1:    width_of = EW'(12);
      3'd2:    width_of = EW'(16);
      3'd3:    width_of = EW'(24);
      3'd4:    width_of = EW'(32);
      default: width_of = '0;
    endcase
  endfunction

  ext_t fr_len, l_len, l_w, r_w, l_d, r_d;
  logic [DIV_W-1:0] half, div_cnt;
  ext_t slot;
  logic hold_vld;
  logic [SMP_W-1:0] hold_l, hold_r, cur_l, cur_r;

  ext_t n_fr, n_lw, n_rw, n_left, n_ld, n_rd;
  logic cfg_ok;

  assign n_fr   = frame_of(cfg_frame_code);
  assign n_lw   = width_of(cfg_left_wcode);
  assign n_rw   = width_of(cfg_right_wcode);
  assign n_left = EW'(cfg_left_len);
  assign n_ld   = EW'(cfg_left_delay);
  assign n_rd   = EW'(cfg_right_delay);

  assign cfg_ok = (n_fr != '0) && (n_lw != '0) && (n_rw != '0) &&
                  (cfg_half_div != '0) && (n_left <= n_fr) &&
                  (n_left >= n_ld + n_lw) &&
                  ((n_fr - n_left) >= (n_rd + n_rw));

  logic launch, halt, fall, step, frame_begin, in_right, in_data, bit_nxt;
  ext_t nxt_slot, pos, d_cur, w_cur, off, idx;
  logic [SMP_W-1:0] src;

  assign launch   = start && !stop && !running;
  assign halt     = stop && running;
  assign fall     = running && bclk && (div_cnt == half - 1'b1);
  assign step     = launch || fall;
  assign nxt_slot = (launch || slot == fr_len - 1'b1) ? '0 : slot + 1'b1;
  assign frame_begin = step && (nxt_slot == '0);
  assign in_right = nxt_slot >= l_len;
  assign pos      = in_right ? nxt_slot - l_len : nxt_slot;
  assign d_cur    = in_right ? r_d : l_d;
  assign w_cur    = in_right ? r_w : l_w;
  assign off      = pos - d_cur;
  assign in_data  = (pos >= d_cur) && (off < w_cur);
  assign idx      = w_cur - 1'b1 - off;

  always_comb begin
    if (frame_begin)
      src = hold_vld ? (in_right ? hold_r : hold_l) : '0;
    else
      src = in_right ? cur_r : cur_l;
  end

  assign bit_nxt   = in_data && |(src & (SMP_W'(1) << idx));
  assign smp_ready = !hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_len   <= EW'(64);
      l_len    <= EW'(32);
      l_w      <= EW'(16);
      r_w      <= EW'(16);
      l_d      <= EW'(1);
      r_d      <= EW'(1);
      half     <= DIV_W'(2);
      cfg_busy <= 1'b0;
      cfg_err  <= 1'b0;
      running  <= 1'b0;
      bclk     <= 1'b0;
      ws       <= 1'b0;
      sdo      <= 1'b0;
      underrun <= 1'b0;
      div_cnt  <= '0;
      slot     <= '0;
      hold_vld <= 1'b0;
      hold_l   <= '0;
      hold_r   <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
    end else begin
      underrun <= 1'b0;
      if (cfg_we) begin
        cfg_busy <= running;
        cfg_err  <= !running && !cfg_ok;
        if (!running && cfg_ok) begin
          fr_len <= n_fr;
          l_len  <= n_left;
          l_w    <= n_lw;
          r_w    <= n_rw;
          l_d    <= n_ld;
          r_d    <= n_rd;
          half   <= cfg_half_div;
        end
      end
      if (smp_valid && !hold_vld) begin
        hold_l   <= smp_left;
        hold_r   <= smp_right;
        hold_vld <= 1'b1;
      end
      if (halt) begin
        running <= 1'b0;
        bclk    <= 1'b0;
        ws      <= 1'b0;
        sdo     <= 1'b0;
        div_cnt <= '0;
      end else if (running || launch) begin
        if (launch) begin
          running <= 1'b1;
          bclk    <= 1'b0;
          div_cnt <= '0;
        end else if (div_cnt == half - 1'b1) begin
          div_cnt <= '0;
          bclk    <= !bclk;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
        if (step) begin
          slot <= nxt_slot;
          ws   <= in_right;
          sdo  <= bit_nxt;
          if (frame_begin) begin
            if (hold_vld) begin
              cur_l    <= hold_l;
              cur_r    <= hold_r;
              hold_vld <= 1'b0;
            end else begin
              cur_l    <= '0;
              cur_r    <= '0;
              underrun <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2s_frame_tx_chk.sv
module i2s_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic stop,
  input logic cfg_we,
  input logic running,
  input logic bclk,
  input logic ws,
  input logic sdo,
  input logic smp_valid,
  input logic smp_ready,
  input logic underrun,
  input logic cfg_busy,
  input logic cfg_err
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!bclk && !ws && !sdo));

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stop) |=> running);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> !running);

  // R3
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && (ws != $past(ws))) |-> $fell(bclk));

  // R3
  stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $rose(bclk)) |-> ($stable(ws) && $stable(sdo)));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  // R8
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && running) |=> (cfg_busy && !cfg_err));

  // R9
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !running) |=> !cfg_busy);
endmodule

bind i2s_frame_tx i2s_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_we(cfg_we),
  .running(running), .bclk(bclk), .ws(ws), .sdo(sdo),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .underrun(underrun),
  .cfg_busy(cfg_busy), .cfg_err(cfg_err)
);

// File: tb/tb_i2s_frame_tx.sv
module tb_i2s_frame_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_frame_code = '0, cfg_left_wcode = '0, cfg_right_wcode = '0;
  logic [7:0] cfg_left_len = '0, cfg_left_delay = '0, cfg_right_delay = '0;
  logic [7:0] cfg_half_div = '0;
  logic cfg_busy, cfg_err, running, smp_ready, bclk, ws, sdo, underrun;
  logic smp_valid = 1'b0;
  logic [31:0] smp_left = '0, smp_right = '0;

  i2s_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_we(cfg_we),
    .cfg_frame_code(cfg_frame_code), .cfg_left_len(cfg_left_len),
    .cfg_left_wcode(cfg_left_wcode), .cfg_right_wcode(cfg_right_wcode),
    .cfg_left_delay(cfg_left_delay), .cfg_right_delay(cfg_right_delay),
    .cfg_half_div(cfg_half_div), .cfg_busy(cfg_busy), .cfg_err(cfg_err),
    .running(running), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .bclk(bclk), .ws(ws),
    .sdo(sdo), .underrun(underrun)
  );

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0, ur_cnt = 0;
  int m_fl = 64, m_ll = 32, m_lw = 16, m_rw = 16, m_ld = 1, m_rd = 1, m_hd = 2;
  logic [31:0] seed = 32'h1234_5678;
  logic [1:0] expq[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int frame_len(input int c);
    int t[7] = '{16, 24, 32, 48, 64, 96, 128};
    return t[c];
  endfunction

  function automatic int width_len(input int c);
    int t[5] = '{8, 12, 16, 24, 32};
    return t[c];
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ {seed[15:0], seed[31:16]};
  endfunction

  // R4 R5 R6: reference frame built from the requirements
  task automatic push_frame(input logic [31:0] l, input logic [31:0] r);
    for (int s = 0; s < m_fl; s++) begin
      logic w_s, b;
      int p, d, w;
      logic [31:0] smp;
      w_s = (s >= m_ll);
      p   = w_s ? s - m_ll : s;
      d   = w_s ? m_rd : m_ld;
      w   = w_s ? m_rw : m_lw;
      smp = w_s ? r : l;
      b   = (p >= d && p < d + w) ? smp[w - 1 - (p - d)] : 1'b0;
      expq.push_back({w_s, b});
    end
  endtask

  logic prev_bclk = 1'b0;
  int since_rise = 0;
  bit seen_rise = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] e;
      if (underrun) ur_cnt++;
      if (!running) seen_rise = 0;
      since_rise++;
      if (bclk && !prev_bclk) begin
        if (seen_rise) chk(since_rise == 2 * m_hd, "R3", "bit clock period", since_rise, 2 * m_hd);
        seen_rise  = 1;
        since_rise = 0;
        if (expq.size() > 0) begin
          e = expq.pop_front();
          chk(ws == e[1], "R4", "phase select", ws, e[1]);
          chk(sdo == e[0], "R5", "serial data R6", sdo, e[0]);
        end
      end
      prev_bclk = bclk;
    end
  end

  task automatic write_cfg(input int fc, input int ll, input int lwc, input int rwc,
                           input int ld, input int rd, input int hd, input bit exp_err);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_frame_code = 3'(fc); cfg_left_len = 8'(ll);
    cfg_left_wcode = 3'(lwc); cfg_right_wcode = 3'(rwc);
    cfg_left_delay = 8'(ld); cfg_right_delay = 8'(rd); cfg_half_div = 8'(hd);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err == exp_err, "R10", "config error flag", cfg_err, exp_err);
    chk(cfg_busy == 1'b0, "R9", "busy after idle write", cfg_busy, 0);
    if (!exp_err) begin
      m_fl = frame_len(fc); m_ll = ll; m_lw = width_len(lwc); m_rw = width_len(rwc);
      m_ld = ld; m_rd = rd; m_hd = hd;
    end
  endtask

  task automatic feed(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(smp_ready == 1'b0, "R7", "ready after accept", smp_ready, 0);
  endtask

  task automatic run_frames(input int n, input bit poke);
    logic [31:0] ls[8], rs[8];
    ur_cnt = 0;
    for (int i = 0; i < n; i++) begin
      ls[i] = rnd(); rs[i] = rnd();
      push_frame(ls[i], rs[i]);
    end
    push_frame('0, '0); // R8 silent frame after the last pair
    feed(ls[0], rs[0]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(running == 1'b1, "R2", "running after start", running, 1);
    for (int i = 1; i < n; i++) begin
      feed(ls[i], rs[i]);
      if (poke && i == 1) begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_frame_code = 3'd0; cfg_left_len = 8'd8;
        cfg_left_wcode = 3'd0; cfg_right_wcode = 3'd0;
        cfg_left_delay = 8'd0; cfg_right_delay = 8'd0; cfg_half_div = 8'd1;
        @(negedge clk); cfg_we = 1'b0;
        chk(cfg_busy == 1'b1, "R9", "busy on running write", cfg_busy, 1);
        chk(cfg_err == 1'b0, "R9", "no error on refused write", cfg_err, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(running == 1'b1, "R2", "running after repeated start", running, 1);
      end
    end
    while (expq.size() != 0) @(negedge clk);
    chk(ur_cnt >= 1, "R8", "underrun pulses seen", ur_cnt, 1);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(running == 1'b0, "R2", "running after stop", running, 0);
    chk({bclk, ws, sdo} == 3'b000, "R1", "idle outputs", {bclk, ws, sdo}, 0);
    chk(smp_ready == 1'b1, "R7", "ready with empty reserve", smp_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bclk, ws, sdo, running} == 4'b0000, "R1", "reset outputs", {bclk, ws, sdo, running}, 0);
    chk(smp_ready == 1'b1, "R1", "reset ready", smp_ready, 1);
    chk({cfg_busy, cfg_err, underrun} == 3'b000, "R1", "reset flags", {cfg_busy, cfg_err, underrun}, 0);

    run_frames(3, 1'b1);

    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (8) @(negedge clk);
    chk({running, bclk, ws, sdo} == 4'b0000, "R2", "stop while idle", {running, bclk, ws, sdo}, 0);

    write_cfg(3, 20, 1, 3, 3, 2, 1, 1'b0);
    run_frames(3, 1'b0);
    write_cfg(0, 8, 0, 0, 0, 0, 3, 1'b0);
    run_frames(2, 1'b0);
    write_cfg(6, 96, 4, 3, 5, 4, 1, 1'b0);
    run_frames(2, 1'b0);

    write_cfg(0, 10, 0, 0, 3, 0, 1, 1'b1);
    write_cfg(0, 20, 0, 0, 0, 0, 1, 1'b1);
    write_cfg(2, 16, 0, 2, 0, 1, 1, 1'b1);
    write_cfg(1, 12, 5, 0, 0, 0, 1, 1'b1);
    write_cfg(4, 32, 2, 2, 1, 1, 0, 1'b1);
    run_frames(1, 1'b0); // R10: previous settings still in force

    write_cfg(2, 16, 0, 0, 0, 0, 2, 1'b0);
    chk(cfg_err == 1'b0, "R10", "error cleared by valid write", cfg_err, 0);
    run_frames(2, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule